// File: doc/BRIEF.md
# Time-Aware Egress Gate Scheduler

This block drives the per-traffic-class transmission gates of a set of egress ports. Each port has eight classes, and bit n of an 8-bit gate vector opens the gate of class n. Each port also has its own cyclic gate control list. Every list entry pairs a gate vector with an interval counted in 200 ns slots. Software fills a port's list through a shared write port, then arms the port with a commit that carries the list length, an absolute start time in nanoseconds and a default gate vector. Until the start time arrives on the synchronized time input, the gates hold the default vector. After that, the port walks its entries in order and wraps back to entry 0 when the last interval ends. Each time a new entry is applied, the port produces a one-cycle event pulse.

Time is quantized to 200 ns slots (`now_ns / SLOT_NS`). Every gate event belongs to the slot in which it was scheduled. The block compares the events of all ports and raises a conflict pulse when two ports place events in the same slot. A halt returns a port to idle, so that a new list can be loaded and committed.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, every gate output is 1 (all classes open), and `running`, `gate_evt`, `cfg_err` and `conflict` are 0.
- R2: Between an accepted commit and the first slot at or after the start time, a port shows the committed default gate vector, produces no event and consumes no entry.
- R3: A port applies the gate vector of entry 0 and pulses its event bit on the second clock edge after `now_ns / 200` first reaches `base_ns / 200`.
- R4: An entry stays applied until its interval, counted in 200 ns slots, has elapsed. The next entry is then applied together with an event pulse, and the gates do not change between events.
- R5: After the last entry of the committed length, a port wraps to entry 0. Each cycle therefore starts exactly one sum of all intervals after the previous one.
- R6: Gate bit n controls class n. A two-entry list (class 7 alone for 500 slots, classes 0 to 6 for 2000 slots) never opens class 7 together with any other class.
- R7: A commit whose length is 0 or larger than DEPTH, or whose first `len` entries include an interval of 0, is rejected. It produces a one-cycle `cfg_err` pulse, and the port stays idle.
- R8: A commit addressed to a port that is not idle is ignored. It changes neither the gates nor `running`, and raises no `cfg_err`.
- R9: A table write addressed to a port that is not idle is discarded and leaves that port's list unchanged.
- R10: `halt[p]` returns port p to idle on the next edge, restores its default gates, and clears the record of its last event for conflict checking.
- R11: `conflict` pulses one cycle after an event when two ports have scheduled events in the same 200 ns slot. It stays 0 when their events fall in different slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_ns | input | TIME_W | Synchronized time in nanoseconds |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_port | input | PSEL_W | Target port of a write or commit |
| cfg_addr | input | IDX_W | Entry index to write |
| cfg_mask | input | NCLS | Gate vector of the written entry |
| cfg_intv | input | INTV_W | Interval of the written entry in slots |
| commit | input | 1 | Arm the selected port |
| commit_len | input | LEN_W | Number of entries in the cycle |
| commit_base_ns | input | TIME_W | Absolute start time in ns |
| commit_dflt | input | NCLS | Gate vector shown while not running |
| halt | input | NPORT | Per-port return to idle |
| gate_open | output | NPORT*NCLS | Gate vectors, port p at bits [p*NCLS +: NCLS] |
| gate_evt | output | NPORT | Per-port gate event pulse |
| running | output | NPORT | Port armed or running |
| cfg_err | output | 1 | Rejected commit pulse |
| conflict | output | 1 | Same-slot event collision pulse |

## Verification
The bench builds the block with NPORT=2, DEPTH=16, TIME_W=48, INTV_W=20 and SLOT_NS=200. Two ports are enough to produce both a same-slot collision (start times 100 ns apart) and a near miss (start times one slot apart). The 48-bit time and 20-bit intervals allow start times aligned to whole seconds and a 500 µs cycle with entries of 100 µs and 400 µs. DEPTH=16 allows a length of 17 to be tried as an out-of-range commit.

// File: rtl/tas_pkg.sv
package tas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } tas_state_t;
endpackage

// File: rtl/tas_slot_quant.sv
module tas_slot_quant #(
  parameter int TIME_W  = 48,
  parameter int SLOT_NS = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now_ns,
  output logic [TIME_W-1:0] cur_slot
);
  always_ff @(posedge clk) begin
    if (rst) cur_slot <= '0;
    else     cur_slot <= now_ns / TIME_W'(SLOT_NS);
  end
endmodule

// File: rtl/tas_gate_table.sv
module tas_gate_table #(
  parameter int DEPTH  = 16,
  parameter int NCLS   = 8,
  parameter int INTV_W = 20,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [NCLS-1:0]   wmask,
  input  logic [INTV_W-1:0] wintv,
  input  logic [IDX_W-1:0]  raddr,
  output logic [NCLS-1:0]   rmask,
  output logic [INTV_W-1:0] rintv,
  input  logic [LEN_W-1:0]  chk_len,
  output logic              chk_ok
);
  logic [NCLS-1:0]   mask_mem [DEPTH];
  logic [INTV_W-1:0] intv_mem [DEPTH];
  logic [DEPTH-1:0]  zero_flag;
  logic              bad;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (we) begin
      mask_mem[waddr] <= wmask;
      intv_mem[waddr] <= wintv;
    end
  end

  // unwritten entries count as zero length
  always_ff @(posedge clk) begin
    if (rst)     zero_flag <= '1;
    else if (we) zero_flag[waddr] <= (wintv == '0);
  end

  assign rmask = mask_mem[raddr];
  assign rintv = intv_mem[raddr];

  always_comb begin
    bad = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      if ((LEN_W'(k) < chk_len) && zero_flag[k]) bad = 1'b1;
    chk_ok = (chk_len != '0) && (chk_len <= LEN_W'(DEPTH)) && !bad;
  end
endmodule

// File: rtl/tas_gate_engine.sv
module tas_gate_engine
  import tas_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NCLS    = 8,
  parameter int INTV_W  = 20,
  parameter int TIME_W  = 48,
  parameter int SLOT_NS = 200,
  parameter logic [NCLS-1:0] DFLT = '1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] cur_slot,
  input  logic              commit,
  input  logic [LEN_W-1:0]  commit_len,
  input  logic [TIME_W-1:0] commit_base_ns,
  input  logic [NCLS-1:0]   commit_dflt,
  input  logic              table_ok,
  input  logic              halt,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [NCLS-1:0]   rd_mask,
  input  logic [INTV_W-1:0] rd_intv,
  output logic [NCLS-1:0]   gate,
  output logic              evt,
  output logic [TIME_W-1:0] evt_slot,
  output logic              running,
  output logic              cfg_err
);
  tas_state_t        st;
  logic [IDX_W-1:0]  idx, nidx;
  logic [LEN_W-1:0]  len;
  logic [TIME_W-1:0] base_slot, nxt_slot;
  logic [NCLS-1:0]   dflt;

  assign nidx    = (idx == IDX_W'(len - LEN_W'(1))) ? '0 : idx + IDX_W'(1);
  assign rd_idx  = (st == ST_RUN) ? nidx : '0;
  assign running = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; idx <= '0; len <= '0;
      base_slot <= '0; nxt_slot <= '0; evt_slot <= '0;
      dflt <= DFLT; gate <= DFLT; evt <= 1'b0; cfg_err <= 1'b0;
    end else begin
      evt <= 1'b0;
      cfg_err <= 1'b0;
      if (halt) begin
        st <= ST_IDLE;
        gate <= dflt;
      end else begin
        case (st)
          ST_IDLE: if (commit) begin
            if (table_ok) begin
              st <= ST_WAIT;
              len <= commit_len;
              base_slot <= commit_base_ns / TIME_W'(SLOT_NS);
              dflt <= commit_dflt;
              gate <= commit_dflt;
            end else begin
              cfg_err <= 1'b1;
            end
          end
          ST_WAIT: if (cur_slot >= base_slot) begin
            st <= ST_RUN;
            idx <= '0;
            gate <= rd_mask;
            nxt_slot <= base_slot + TIME_W'(rd_intv);
            evt <= 1'b1;
            evt_slot <= base_slot;
          end
          ST_RUN: if (cur_slot >= nxt_slot) begin
            idx <= nidx;
            gate <= rd_mask;
            nxt_slot <= nxt_slot + TIME_W'(rd_intv);
            evt <= 1'b1;
            evt_slot <= nxt_slot;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R2
  idle_dflt_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_RUN) |-> (gate == dflt));
  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && $past(st) == ST_RUN && !evt) |-> $stable(gate));
  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (LEN_W'(idx) < len));
  // R3
  evt_run_chk: assert property (@(posedge clk) disable iff (rst)
    evt |-> (st == ST_RUN));
  // R10
  halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> !running);
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
  parameter int NPORT   = 2,
  parameter int DEPTH   = 16,
  parameter int NCLS    = 8,
  parameter int INTV_W  = 20,
  parameter int TIME_W  = 48,
  parameter int SLOT_NS = 200,
  parameter logic [NCLS-1:0] DFLT = '1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TIME_W-1:0]     now_ns,
  input  logic                  cfg_we,
  input  logic [PSEL_W-1:0]     cfg_port,
  input  logic [IDX_W-1:0]      cfg_addr,
  input  logic [NCLS-1:0]       cfg_mask,
  input  logic [INTV_W-1:0]     cfg_intv,
  input  logic                  commit,
  input  logic [LEN_W-1:0]      commit_len,
  input  logic [TIME_W-1:0]     commit_base_ns,
  input  logic [NCLS-1:0]       commit_dflt,
  input  logic [NPORT-1:0]      halt,
  output logic [NPORT*NCLS-1:0] gate_open,
  output logic [NPORT-1:0]      gate_evt,
  output logic [NPORT-1:0]      running,
  output logic                  cfg_err,
  output logic                  conflict
);
  logic [TIME_W-1:0] cur_slot;
  logic [TIME_W-1:0] evt_slot  [NPORT];
  logic [TIME_W-1:0] last_slot [NPORT];
  logic [NPORT-1:0]  last_v, err_p;
  logic              hit;

  tas_slot_quant #(.TIME_W(TIME_W), .SLOT_NS(SLOT_NS)) i_quant (
    .clk(clk), .rst(rst), .now_ns(now_ns), .cur_slot(cur_slot));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic              sel, ok;
    logic [IDX_W-1:0]  ridx;
    logic [NCLS-1:0]   rmask;
    logic [INTV_W-1:0] rintv;

    assign sel = (cfg_port == PSEL_W'(p));

    tas_gate_table #(.DEPTH(DEPTH), .NCLS(NCLS), .INTV_W(INTV_W)) i_tab (
      .clk(clk), .rst(rst),
      .we(cfg_we && sel && !running[p]),
      .waddr(cfg_addr), .wmask(cfg_mask), .wintv(cfg_intv),
      .raddr(ridx), .rmask(rmask), .rintv(rintv),
      .chk_len(commit_len), .chk_ok(ok));

    tas_gate_engine #(.DEPTH(DEPTH), .NCLS(NCLS), .INTV_W(INTV_W),
                      .TIME_W(TIME_W), .SLOT_NS(SLOT_NS), .DFLT(DFLT)) i_eng (
      .clk(clk), .rst(rst), .cur_slot(cur_slot),
      .commit(commit && sel), .commit_len(commit_len),
      .commit_base_ns(commit_base_ns), .commit_dflt(commit_dflt),
      .table_ok(ok), .halt(halt[p]),
      .rd_idx(ridx), .rd_mask(rmask), .rd_intv(rintv),
      .gate(gate_open[p*NCLS +: NCLS]), .evt(gate_evt[p]),
      .evt_slot(evt_slot[p]), .running(running[p]), .cfg_err(err_p[p]));

    always_ff @(posedge clk) begin
      if (rst || halt[p]) begin
        last_v[p] <= 1'b0;
        last_slot[p] <= '0;
      end else if (gate_evt[p]) begin
        last_v[p] <= 1'b1;
        last_slot[p] <= evt_slot[p];
      end
    end
  end

  assign cfg_err = |err_p;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NPORT; i++)
      for (int j = 0; j < NPORT; j++)
        if (i != j && gate_evt[i] &&
            ((gate_evt[j] && evt_slot[j] == evt_slot[i]) ||
             (last_v[j] && last_slot[j] == evt_slot[i])))
          hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) conflict <= 1'b0;
    else     conflict <= hit;
  end

  // R11
  conflict_src_chk: assert property (@(posedge clk) disable iff (rst)
    conflict |-> $past(|gate_evt));
endmodule

// File: tb/test_tas_gate_sched.sv
module test_tas_gate_sched;
  localparam int NPORT = 2, DEPTH = 16, NCLS = 8, INTV_W = 20, TIME_W = 48;
  localparam int IDX_W = 4, LEN_W = 5, PSEL_W = 1;

  logic clk = 0, rst = 1;
  logic [TIME_W-1:0] now_ns = '0;
  logic cfg_we = 0, commit = 0;
  logic [PSEL_W-1:0] cfg_port = '0;
  logic [IDX_W-1:0] cfg_addr = '0;
  logic [NCLS-1:0] cfg_mask = '0, commit_dflt = '1;
  logic [INTV_W-1:0] cfg_intv = '0;
  logic [LEN_W-1:0] commit_len = '0;
  logic [TIME_W-1:0] commit_base_ns = '0;
  logic [NPORT-1:0] halt = '0;
  logic [NPORT*NCLS-1:0] gate_open;
  logic [NPORT-1:0] gate_evt, running;
  logic cfg_err, conflict;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tas_gate_sched #(.NPORT(NPORT), .DEPTH(DEPTH), .NCLS(NCLS), .INTV_W(INTV_W),
                   .TIME_W(TIME_W), .SLOT_NS(200)) i_tas_gate_sched (
    .clk(clk), .rst(rst), .now_ns(now_ns), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_intv(cfg_intv),
    .commit(commit), .commit_len(commit_len), .commit_base_ns(commit_base_ns),
    .commit_dflt(commit_dflt), .halt(halt), .gate_open(gate_open),
    .gate_evt(gate_evt), .running(running), .cfg_err(cfg_err), .conflict(conflict));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int p, int a, logic [7:0] m, int iv);
    @(negedge clk);
    cfg_we = 1; cfg_port = PSEL_W'(p); cfg_addr = IDX_W'(a);
    cfg_mask = m; cfg_intv = INTV_W'(iv);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // commit and return the sampled cfg_err
  task automatic do_commit(int p, int len, longint base, logic [7:0] d, output logic err);
    @(negedge clk);
    commit = 1; cfg_port = PSEL_W'(p); commit_len = LEN_W'(len);
    commit_base_ns = TIME_W'(base); commit_dflt = d;
    @(negedge clk);
    err = cfg_err;
    commit = 0;
  endtask

  task automatic step(longint t);
    @(negedge clk);
    now_ns = TIME_W'(t);
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic do_halt(logic [1:0] h);
    @(negedge clk); halt = h; @(negedge clk); halt = '0;
  endtask

  task automatic t_reset();
    check("R1 gates", 32'(gate_open), 32'hFFFF);
    check("R1 running", 32'(running), 0);
    check("R1 evt/err/conflict", {29'd0, |gate_evt, cfg_err, conflict}, 0);
  endtask

  task automatic t_cycle();
    logic e;
    longint b = 64'd1_000_000_000;
    wr(0, 0, 8'h80, 500);
    wr(0, 1, 8'h7F, 2000);
    do_commit(0, 2, b, 8'hFF, e);
    check("R7 valid commit no err", 32'(e), 0);
    step(b - 1);
    check("R2 default before base", 32'(gate_open[7:0]), 32'hFF);
    check("R2 no event before base", 32'(gate_evt[0]), 0);
    check("R2 armed", 32'(running[0]), 1);
    step(b);
    check("R3 entry0 at base", 32'(gate_open[7:0]), 32'h80);
    check("R3 event at base", 32'(gate_evt[0]), 1);
    step(b + 99_999);
    check("R4 hold entry0", 32'(gate_open[7:0]), 32'h80);
    check("R4 no event mid-entry", 32'(gate_evt[0]), 0);
    step(b + 100_000);
    check("R6 classes0-6 only", 32'(gate_open[7:0]), 32'h7F);
    check("R4 event at entry1", 32'(gate_evt[0]), 1);
    step(b + 499_999);
    check("R4 hold entry1", 32'(gate_open[7:0]), 32'h7F);
    step(b + 500_000);
    check("R5 wrap to entry0", 32'(gate_open[7:0]), 32'h80);
    check("R5 wrap event", 32'(gate_evt[0]), 1);
    step(b + 600_000);
    check("R5 second cycle entry1", 32'(gate_open[7:0]), 32'h7F);
  endtask

  task automatic t_locked();
    logic e;
    do_commit(0, 1, 0, 8'h00, e);
    check("R8 no err on busy commit", 32'(e), 0);
    @(negedge clk);
    check("R8 gates unchanged", 32'(gate_open[7:0]), 32'h7F);
    check("R8 still running", 32'(running[0]), 1);
    wr(0, 0, 8'h0F, 500);
    do_halt(2'b01);
    check("R10 halt idle", 32'(running[0]), 0);
    check("R10 halt default gates", 32'(gate_open[7:0]), 32'hFF);
    do_commit(0, 2, 64'd2_000_000_000, 8'h3C, e);
    step(64'd1_999_999_999);
    check("R2 programmed default", 32'(gate_open[7:0]), 32'h3C);
    step(64'd2_000_000_000);
    check("R9 write while running ignored", 32'(gate_open[7:0]), 32'h80);
    do_halt(2'b01);
  endtask

  task automatic t_errors();
    logic e;
    wr(0, 2, 8'h01, 0);
    do_commit(0, 3, 64'd2_500_000_000, 8'hFF, e);
    check("R7 zero interval err", 32'(e), 1);
    check("R7 stays idle", 32'(running[0]), 0);
    do_commit(0, 0, 64'd2_500_000_000, 8'hFF, e);
    check("R7 len 0 err", 32'(e), 1);
    do_commit(0, 17, 64'd2_500_000_000, 8'hFF, e);
    check("R7 len over depth err", 32'(e), 1);
    do_commit(0, 2, 64'd2_500_000_000, 8'hFF, e);
    check("R7 len 2 accepted", {30'd0, e, running[0]}, 32'h1);
    do_halt(2'b01);
  endtask

  task automatic t_conflict();
    logic e;
    longint b = 64'd3_000_000_000;
    wr(0, 0, 8'h01, 1000);
    wr(1, 0, 8'h02, 3);
    do_commit(0, 1, b, 8'hFF, e);
    do_commit(1, 1, b + 100, 8'hFF, e);
    step(b);
    check("R11 both fire", 32'(gate_evt), 32'h3);
    @(negedge clk);
    check("R11 same-slot conflict", 32'(conflict), 1);
    do_halt(2'b11);
    b = 64'd4_000_000_000;
    do_commit(0, 1, b, 8'hFF, e);
    do_commit(1, 1, b + 200, 8'hFF, e);
    step(b);
    check("R11 port0 fires alone", 32'(gate_evt), 32'h1);
    @(negedge clk);
    check("R11 no conflict first", 32'(conflict), 0);
    step(b + 200);
    check("R11 port1 gates", 32'(gate_open[15:8]), 32'h02);
    @(negedge clk);
    check("R10/R11 next slot no conflict", 32'(conflict), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_cycle();
    t_locked();
    t_errors();
    t_conflict();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule